// File: doc/BRIEF.md
# Packed Decimal Shift-and-Round Unit

This unit takes a signed packed-decimal number and moves its magnitude by a whole number of decimal digits. The number is 31 four-bit decimal digits above a four-bit sign code in the lowest nibble. A signed count sets the direction: a positive count moves digits toward the top and a negative count moves them toward the bottom. When digits leave at the bottom, the result is rounded half-up. The unit then writes a preferred sign code and reports how the result compares with zero, together with a summary flag for lost digits or a malformed operand.

Operands come in on a valid/ready channel and results leave on another valid/ready channel. A single output register sits between the two. An operand is taken on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so the unit can take one operation per cycle. A stalled consumer holds the current result in place and also stalls the producer. The sign-code mode pin is plain control and is sampled along with the operand.

Top module: `dec_shift_round`

## Requirements
- R1: The operand is valid only when every digit nibble (bits 127:4) is 0..9 and the sign nibble (bits 3:0) is 0xA..0xF. For an invalid operand the result is all zeros and the condition is 4'b0001.
- R2: The count is an 8-bit two's-complement value and is limited to the range -31..+31 before use, so for example 100 acts as 31 and -128 acts as -31.
- R3: The sign nibble is cleared before the shift. A positive count k moves every digit k places toward bit 127 and fills the vacated low digits with zero.
- R4: On a left move, if any nonzero digit is pushed beyond digit 31, condition bit 0 is set.
- R5: A negative count -k moves digits k places toward bit 0. If the digit that lands in the sign position is 5 or more, decimal one is added to the units digit, with the carry rippling through any run of 9s.
- R6: A count of zero leaves the magnitude unchanged and never rounds.
- R7: The result sign nibble is 0xD when the input sign is 0xB or 0xD. For any other valid sign it is 0xC when `in_pos_f` is 0 and 0xF when `in_pos_f` is 1. This holds even when the result is zero.
- R8: The condition is {lt, gt, eq, so} in bits 3..0. eq is set when the result magnitude is zero, whatever the sign. lt is set for a negative sign with a nonzero magnitude, and gt for a positive sign with a nonzero magnitude. At most one of bits 3..1 is set.
- R9: `in_ready` equals `!out_valid || out_ready`. An accepted operand's result appears with `out_valid` on the next cycle. While `out_valid` is high and `out_ready` is low, `out_result` and `out_cond` hold steady.
- R10: During reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_operand | input | 128 | Packed-decimal operand, sign in bits 3:0 |
| in_count | input | 8 | Signed digit count, positive = toward the top |
| in_pos_f | input | 1 | Positive sign code select: 0 gives 0xC, 1 gives 0xF |
| out_valid | output | 1 | Result held in output register |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 128 | Shifted, rounded, re-signed value |
| out_cond | output | 4 | {lt, gt, eq, so} |

## Verification
The assertions check several properties on every cycle. They confirm that the output holds steady under back-pressure, that at most one compare flag is set, and that a result carrying a compare flag has a preferred sign code with 0xD whenever lt is set. They also check that an invalid operand always produces the flag-only condition, and that the rounding increment never carries out of the top digit. Only the bench scenarios can show the arithmetic itself. That covers count clamping at both extremes, overflow detection, the round-up ripple through a long run of 9s, the zero-count case, and the sign choice for each input sign code and mode.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  localparam logic [3:0] SGN_NEG   = 4'hD;
  localparam logic [3:0] SGN_POS_C = 4'hC;
  localparam logic [3:0] SGN_POS_F = 4'hF;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;

  function automatic logic code_is_neg(input logic [3:0] code);
    return (code == 4'hB) || (code == 4'hD);
  endfunction

endpackage

// File: rtl/dsr_check.sv
module dsr_check #(
  parameter int DIGITS = 31,
  localparam int W = 4 * (DIGITS + 1)
) (
  input  logic [W-1:0] op,
  output logic         ok,
  output logic         neg
);
  import dsr_pkg::*;

  logic [DIGITS-1:0] dig_ok;

  for (genvar i = 1; i <= DIGITS; i++) begin : g_dig
    assign dig_ok[i-1] = (op[4*i +: 4] <= 4'd9);
  end

  assign ok  = (&dig_ok) && (op[3:0] >= 4'hA);
  assign neg = code_is_neg(op[3:0]);
endmodule

// File: rtl/dsr_shift.sv
module dsr_shift #(
  parameter int DIGITS = 31,
  parameter int CW = 8,
  localparam int W = 4 * (DIGITS + 1),
  localparam int AW = $clog2(DIGITS + 1)
) (
  input  logic [W-1:0]  mag,
  input  logic [CW-1:0] cnt,
  output logic [W-1:0]  shifted,
  output logic          ovf,
  output logic          rnd_up
);
  localparam logic signed [CW-1:0] LIM_POS = CW'(DIGITS);
  localparam logic signed [CW-1:0] LIM_NEG = -CW'(DIGITS);

  logic signed [CW-1:0] c;
  logic                 go_left;
  logic [AW-1:0]        amt;
  logic [2*W-1:0]       wide;
  logic [W-1:0]         rsh;

  assign c       = $signed(cnt);
  assign go_left = !c[CW-1];

  always_comb begin
    if (go_left) begin
      amt = (c > LIM_POS) ? AW'(DIGITS) : AW'(c);
    end else begin
      amt = (c < LIM_NEG) ? AW'(DIGITS) : AW'(-c);
    end
  end

  assign wide    = {{W{1'b0}}, mag} << {amt, 2'b00};
  assign rsh     = mag >> {amt, 2'b00};
  assign shifted = go_left ? wide[W-1:0] : rsh;
  assign ovf     = go_left && (|wide[2*W-1:W]);
  assign rnd_up  = !go_left && (rsh[3:0] >= 4'd5);
endmodule

// File: rtl/dsr_incr.sv
module dsr_incr #(
  parameter int DIGITS = 31,
  localparam int W = 4 * (DIGITS + 1)
) (
  input  logic [W-1:0] val,
  input  logic         inc,
  output logic [W-1:0] sum,
  output logic         carry_out
);
  logic [DIGITS:0] c;

  assign c[0]     = inc;
  assign sum[3:0] = 4'h0;

  for (genvar i = 1; i <= DIGITS; i++) begin : g_dig
    logic [3:0] d;
    assign d = val[4*i +: 4];
    assign sum[4*i +: 4] = c[i-1] ? ((d == 4'd9) ? 4'd0 : d + 4'd1) : d;
    assign c[i] = c[i-1] && (d == 4'd9);
  end

  assign carry_out = c[DIGITS];
endmodule

// File: rtl/dec_shift_round.sv
module dec_shift_round #(
  parameter int DIGITS = 31,
  parameter int CW = 8,
  localparam int W = 4 * (DIGITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_operand,
  input  logic [CW-1:0] in_count,
  input  logic          in_pos_f,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_result,
  output logic [3:0]    out_cond
);
  import dsr_pkg::*;

  logic          op_ok, op_neg;
  logic [W-1:0]  mag, shifted, inc_sum;
  logic          ovf, rnd_up, inc_carry;
  logic          mag_zero;
  logic [3:0]    sgn_code;
  logic [W-1:0]  res_next;
  cond_t         cond_next, cond_q;
  logic          take;

  assign mag = {in_operand[W-1:4], 4'h0};

  dsr_check #(.DIGITS(DIGITS)) u_check (
    .op(in_operand), .ok(op_ok), .neg(op_neg)
  );

  dsr_shift #(.DIGITS(DIGITS), .CW(CW)) u_shift (
    .mag(mag), .cnt(in_count), .shifted(shifted), .ovf(ovf), .rnd_up(rnd_up)
  );

  dsr_incr #(.DIGITS(DIGITS)) u_incr (
    .val(shifted), .inc(rnd_up), .sum(inc_sum), .carry_out(inc_carry)
  );

  assign mag_zero = ~|inc_sum[W-1:4];
  assign sgn_code = op_neg ? SGN_NEG : (in_pos_f ? SGN_POS_F : SGN_POS_C);

  always_comb begin
    if (op_ok) begin
      res_next     = {inc_sum[W-1:4], sgn_code};
      cond_next.lt = op_neg && !mag_zero;
      cond_next.gt = !op_neg && !mag_zero;
      cond_next.eq = mag_zero;
      cond_next.so = ovf;
    end else begin
      res_next  = '0;
      cond_next = '{lt: 1'b0, gt: 1'b0, eq: 1'b0, so: 1'b1};
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      cond_q     <= '0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_result <= res_next;
      cond_q     <= cond_next;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  assign out_cond = cond_q;

  // Back-pressure keeps the held result frozen (R9)
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_cond));

  // Compare flags are mutually exclusive (R8)
  assert_cond_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_cond[3:1]));

  // Any compared result carries a preferred sign code, 0xD when negative (R7)
  assert_sign_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (|out_cond[3:1]) |->
      (out_result[3:0] == SGN_POS_C || out_result[3:0] == SGN_POS_F || out_result[3:0] == SGN_NEG)
      && (!out_cond[3] || out_result[3:0] == SGN_NEG));

  // A malformed operand yields only the summary flag and a zero result (R1)
  assert_invalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take && !op_ok |=> out_cond == 4'b0001 && out_result == '0);

  // Rounding after a right move never carries out of the top digit (R5)
  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && rnd_up |-> !inc_carry);
endmodule

// File: tb/sim_dec_shift_round.sv
module sim_dec_shift_round;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [127:0] in_operand;
  logic [7:0]   in_count;
  logic         in_pos_f;
  logic         out_valid;
  logic         out_ready;
  logic [127:0] out_result;
  logic [3:0]   out_cond;

  int n_cmp = 0;
  int n_bad = 0;

  logic [127:0] q_op[$];
  logic [7:0]   q_cnt[$];
  bit           q_md[$];
  string        q_tag[$];

  bit           m_valid = 1'b0;
  logic [127:0] m_res;
  logic [3:0]   m_cond;
  string        m_tag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_shift_round u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_count(in_count), .in_pos_f(in_pos_f),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_cond(out_cond)
  );

  function automatic void ref_calc(input logic [127:0] op, input logic [7:0] cnt, input bit md,
                                   output logic [127:0] res, output logic [3:0] cond);
    int d[32];
    int n[32];
    bit ok, neg, ovf, rnd, z;
    int k, carry;
    for (int i = 0; i < 32; i++) begin
      d[i] = int'(op[4*i +: 4]);
      n[i] = 0;
    end
    ok = (d[0] >= 10);
    for (int i = 1; i < 32; i++) if (d[i] > 9) ok = 0;
    if (!ok) begin
      res = '0;
      cond = 4'b0001;
      return;
    end
    neg = (d[0] == 11) || (d[0] == 13);
    k = int'($signed(cnt));
    if (k > 31) k = 31;
    if (k < -31) k = -31;
    ovf = 0;
    rnd = 0;
    if (k >= 0) begin
      for (int j = 1; j < 32; j++) begin
        if (j + k <= 31) n[j+k] = d[j];
        else if (d[j] != 0) ovf = 1;
      end
    end else begin
      for (int j = 1; j < 32; j++) begin
        if (j + k >= 1) n[j+k] = d[j];
        else if (j + k == 0) rnd = (d[j] >= 5);
      end
    end
    if (rnd) begin
      carry = 1;
      for (int i = 1; i < 32; i++) begin
        n[i] = n[i] + carry;
        if (n[i] == 10) begin n[i] = 0; carry = 1; end
        else carry = 0;
      end
    end
    z = 1;
    for (int i = 1; i < 32; i++) if (n[i] != 0) z = 0;
    n[0] = neg ? 13 : (md ? 15 : 12);
    for (int i = 0; i < 32; i++) res[4*i +: 4] = 4'(n[i]);
    cond = {neg && !z, !neg && !z, z, ovf};
  endfunction

  task automatic push(input logic [127:0] op, input logic [7:0] cnt, input bit md, input string tag);
    q_op.push_back(op);
    q_cnt.push_back(cnt);
    q_md.push_back(md);
    q_tag.push_back(tag);
  endtask

  // Reference model advances on every clock edge
  always @(posedge clk) begin
    if (rst_n) begin
      if (in_valid && (!m_valid || out_ready)) begin
        ref_calc(in_operand, in_count, in_pos_f, m_res, m_cond);
        m_valid = 1'b1;
        m_tag = q_tag[0];
        void'(q_op.pop_front());
        void'(q_cnt.pop_front());
        void'(q_md.pop_front());
        void'(q_tag.pop_front());
      end else if (out_ready) begin
        m_valid = 1'b0;
      end
    end
  end

  task automatic compare();
    bit exp_rdy;
    exp_rdy = !m_valid || out_ready;
    n_cmp++;
    if (in_ready !== exp_rdy || out_valid !== m_valid) begin
      n_bad++;
      $display("FAIL R9 handshake: in_ready=%0b out_valid=%0b expected %0b %0b",
               in_ready, out_valid, exp_rdy, m_valid);
    end else if (m_valid && (out_result !== m_res || out_cond !== m_cond)) begin
      n_bad++;
      $display("FAIL %s: result=%h cond=%b expected %h %b", m_tag, out_result, out_cond, m_res, m_cond);
    end
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog expired: actual hung, expected drained queue");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_operand = '0;
    in_count = '0;
    in_pos_f = 1'b0;
    out_ready = 1'b0;

    push(128'h12345C, 8'd2, 1'b0, "R3");
    push(128'h12345D, 8'd3, 1'b1, "R3");
    push({4'h7, 120'h0, 4'hC}, 8'd1, 1'b0, "R4");
    push({4'h0, 4'h2, 116'h0, 4'hC}, 8'd1, 1'b0, "R4");
    push(128'h3C, 8'd30, 1'b0, "R2");
    push(128'h3C, 8'd100, 1'b0, "R2");
    push({4'h6, 120'h0, 4'hC}, 8'h80, 1'b0, "R2");
    push({4'h4, 120'h0, 4'hD}, 8'hE1, 1'b0, "R2");
    push(128'h12345C, 8'hFF, 1'b0, "R5");
    push(128'h12344C, 8'hFF, 1'b0, "R5");
    push({{30{4'h9}}, 4'h5, 4'hC}, 8'hFF, 1'b0, "R5");
    push(128'h9999987D, 8'hFE, 1'b1, "R5");
    push(128'h98765D, 8'd0, 1'b0, "R6");
    push(128'h98765C, 8'd0, 1'b1, "R6");
    push(128'h1A3C, 8'd1, 1'b0, "R1");
    push(128'h1239, 8'd0, 1'b0, "R1");
    push(128'h42A, 8'd1, 1'b1, "R7");
    push(128'h42B, 8'd1, 1'b0, "R7");
    push(128'h42E, 8'd1, 1'b0, "R7");
    push(128'h0D, 8'd0, 1'b0, "R8");
    push(128'h5B, 8'hFF, 1'b0, "R8");
    for (int t = 0; t < 60; t++) begin
      logic [127:0] op;
      for (int i = 1; i < 32; i++) op[4*i +: 4] = 4'($urandom_range(9));
      op[3:0] = 4'($urandom_range(15, 10));
      if (t % 11 == 5) op[4*($urandom_range(31, 1)) +: 4] = 4'hB;
      push(op, 8'($urandom_range(255)), 1'($urandom_range(1)), "R9");
    end

    repeat (2) @(negedge clk);
    n_cmp++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R10 reset: out_valid=%0b in_ready=%0b expected 0 1", out_valid, in_ready);
    end
    rst_n = 1'b1;

    while (q_op.size() > 0 || m_valid) begin
      @(negedge clk);
      compare();
      out_ready = ($urandom_range(3) != 0);
      if (q_op.size() > 0 && $urandom_range(4) != 0) begin
        in_valid = 1'b1;
        in_operand = q_op[0];
        in_count = q_cnt[0];
        in_pos_f = q_md[0];
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    compare();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule